// File: doc/BRIEF.md
# Partition-Aware Multiway Lighting Controller

This block drives the light banks of a row of rooms that removable partitions split apart or join. Each room has one toggle switch and one light bank. Rooms joined by open partitions form one merged space. Every switch in that space toggles all of its lights, so each light shows the exclusive-OR of the switch levels in its own space. Which switches feed a light therefore changes at run time with the partition state.

For each light, a 4:1 selection is steered by whether the partitions on its left and on its right are open. The selection picks the light's own switch level, combined with the parity of the connected run of rooms on either side, on both sides, or on neither. The partition state never changes the structure. A parameter adds an output register stage with an active-low asynchronous reset. With that stage the lights follow the inputs one clock later. Without it the block is purely combinational.

Top module: `partition_light_ctrl`

## Requirements
- R1: With every partition closed (`part_closed` all ones), each light equals the switch of its own room: `light_on == sw_lvl`.
- R2: With every partition open (`part_closed` all zeros), all lights equal the XOR of all switch levels. Any single switch change therefore flips every light.
- R3: With only the middle partition open (`part_closed == 3'b101`), lights 2 and 3 both equal `sw_lvl[1] ^ sw_lvl[2]`. Light 1 follows `sw_lvl[0]` alone and light 4 follows `sw_lvl[3]` alone.
- R4: With only the middle partition closed (`part_closed == 3'b010`), lights 1 and 2 equal `sw_lvl[0] ^ sw_lvl[1]`, and lights 3 and 4 equal `sw_lvl[2] ^ sw_lvl[3]`.
- R5: For every partition combination, `part_closed[k]` (1 = closed) separates room k+1 (`sw_lvl[k]`, `light_on[k]`) from room k+2. A group is a maximal run of rooms joined by open partitions, and each light equals the XOR of the switch levels of its group.
- R6: When `part_closed[k]` is 0, `light_on[k]` and `light_on[k+1]` are equal.
- R7: With the partitions held, flipping one switch inverts exactly the lights of that switch's group and leaves every other light unchanged.
- R8: With `REG_OUT` = 1, a change on the inputs reaches `light_on` at the first rising clock edge after it, and not before.
- R9: While `rst_n` is low, all lights are off (`light_on` all zeros). This applies whether reset is held from start-up or asserted during operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| sw_lvl | input | ROOMS (4) | Switch level per room; bit 0 is room 1 |
| part_closed | input | ROOMS-1 (3) | Partition flags, 1 = closed; bit k sits between room k+1 and room k+2 |
| light_on | output | ROOMS (4) | Light drive per room; bit 0 is room 1 |

## Verification
The bench goes after the mixed partition patterns that sit outside the four named arrangements. Examples are a three-room group on either end and a lone end room next to it. A design that only decodes the named cases, or that looks only at the adjacent partitions instead of the whole connected run, lights the far room of such a group wrongly. Single-switch flips under each of the eight partition patterns would show a light leaking across a closed partition, or a group member that misses the toggle. A latency probe and a mid-run reset would show an output stage that passes inputs through early or keeps stale lights during reset.

// File: rtl/lc_pkg.sv
package lc_pkg;
  // Which neighbours a light merges with: {left side open, right side open}.
  typedef enum logic [1:0] {
    SPAN_SOLO  = 2'b00,
    SPAN_RIGHT = 2'b01,
    SPAN_LEFT  = 2'b10,
    SPAN_BOTH  = 2'b11
  } span_e;

  localparam int ROOMS_DEF = 4;
endpackage

// File: rtl/lc_link_decode.sv
module lc_link_decode #(
  parameter int ROOMS = 4
) (
  input  logic [ROOMS-2:0] part_closed,
  output logic [ROOMS-1:0] open_left,
  output logic [ROOMS-1:0] open_right
);
  // End rooms have no outer partition; treat that side as closed.
  assign open_left[0]        = 1'b0;
  assign open_right[ROOMS-1] = 1'b0;

  for (genvar i = 1; i < ROOMS; i++) begin : g_left
    assign open_left[i] = ~part_closed[i-1];
  end

  for (genvar i = 0; i < ROOMS-1; i++) begin : g_right
    assign open_right[i] = ~part_closed[i];
  end
endmodule

// File: rtl/lc_run_parity.sv
module lc_run_parity #(
  parameter int ROOMS = 4
) (
  input  logic [ROOMS-1:0] sw_lvl,
  input  logic [ROOMS-2:0] part_closed,
  output logic [ROOMS-1:0] left_par,
  output logic [ROOMS-1:0] right_par
);
  // left_par[i]: parity of the connected run that ends at room i-1.
  always_comb begin
    left_par    = '0;
    left_par[1] = sw_lvl[0];
    for (int i = 2; i < ROOMS; i++) begin
      left_par[i] = sw_lvl[i-1] ^ (~part_closed[i-2] & left_par[i-1]);
    end
  end

  // right_par[i]: parity of the connected run that starts at room i+1.
  always_comb begin
    right_par          = '0;
    right_par[ROOMS-2] = sw_lvl[ROOMS-1];
    for (int i = ROOMS-3; i >= 0; i--) begin
      right_par[i] = sw_lvl[i+1] ^ (~part_closed[i+1] & right_par[i+1]);
    end
  end
endmodule

// File: rtl/lc_light_mux.sv
module lc_light_mux
  import lc_pkg::*;
(
  input  logic  own_sw,
  input  logic  lpar,
  input  logic  rpar,
  input  span_e sel,
  output logic  light
);
  always_comb begin
    unique case (sel)
      SPAN_SOLO:  light = own_sw;
      SPAN_RIGHT: light = own_sw ^ rpar;
      SPAN_LEFT:  light = own_sw ^ lpar;
      SPAN_BOTH:  light = own_sw ^ lpar ^ rpar;
      default:    light = own_sw;
    endcase
  end
endmodule

// File: rtl/lc_out_stage.sv
module lc_out_stage #(
  parameter int W       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end else begin : g_wire
    assign q = d;
  end
endmodule

// File: rtl/partition_light_ctrl.sv
module partition_light_ctrl
  import lc_pkg::*;
#(
  parameter int ROOMS   = ROOMS_DEF,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROOMS-1:0] sw_lvl,
  input  logic [ROOMS-2:0] part_closed,
  output logic [ROOMS-1:0] light_on
);
  logic [ROOMS-1:0] open_l;
  logic [ROOMS-1:0] open_r;
  logic [ROOMS-1:0] par_l;
  logic [ROOMS-1:0] par_r;
  logic [ROOMS-1:0] light_c;

  lc_link_decode #(.ROOMS(ROOMS)) u_dec (
    .part_closed (part_closed),
    .open_left   (open_l),
    .open_right  (open_r)
  );

  lc_run_parity #(.ROOMS(ROOMS)) u_par (
    .sw_lvl      (sw_lvl),
    .part_closed (part_closed),
    .left_par    (par_l),
    .right_par   (par_r)
  );

  for (genvar i = 0; i < ROOMS; i++) begin : g_light
    lc_light_mux u_mux (
      .own_sw (sw_lvl[i]),
      .lpar   (par_l[i]),
      .rpar   (par_r[i]),
      .sel    (span_e'({open_l[i], open_r[i]})),
      .light  (light_c[i])
    );
  end

  lc_out_stage #(.W(ROOMS), .REG_OUT(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (light_c),
    .q     (light_on)
  );
endmodule

// File: rtl/partition_light_ctrl_chk.sv
module partition_light_ctrl_chk #(
  parameter int ROOMS   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ROOMS-1:0] sw_lvl,
  input logic [ROOMS-2:0] part_closed,
  input logic [ROOMS-1:0] light_on
);
  if (REG_OUT) begin : g_seq
    AST_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (&part_closed) |=> (light_on == $past(sw_lvl)));  // R1
    AST_ALL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (part_closed == '0) |=> (light_on == {ROOMS{^$past(sw_lvl)}}));  // R2
    for (genvar k = 0; k < ROOMS-1; k++) begin : g_pair
      AST_GROUP_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!part_closed[k]) |=> (light_on[k] == light_on[k+1]));  // R6
    end
    AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $stable(part_closed) &&
       $countones(sw_lvl ^ $past(sw_lvl)) == 1) |=> (light_on != $past(light_on)));  // R7
    AST_RESET_DARK: assert property (@(posedge clk)
      (!rst_n) |=> (light_on == '0));  // R9
  end else begin : g_comb
    AST_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (&part_closed) |-> (light_on == sw_lvl));  // R1
    AST_ALL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (part_closed == '0) |-> (light_on == {ROOMS{^sw_lvl}}));  // R2
    for (genvar k = 0; k < ROOMS-1; k++) begin : g_pair
      AST_GROUP_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!part_closed[k]) |-> (light_on[k] == light_on[k+1]));  // R6
    end
  end
endmodule

bind partition_light_ctrl partition_light_ctrl_chk #(
  .ROOMS(ROOMS), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_lvl(sw_lvl),
  .part_closed(part_closed), .light_on(light_on)
);

// File: tb/partition_light_ctrl_test.sv
`timescale 1ns/1ps
module partition_light_ctrl_test;
  // Entry layout: {part_closed[2:0], sw_lvl[3:0], expected light_on[3:0]}
  localparam int NV = 16;
  localparam logic [10:0] VEC [NV] = '{
    11'b111_1010_1010, 11'b111_0101_0101,
    11'b000_0001_1111, 11'b000_0011_0000, 11'b000_0111_1111,
    11'b101_0010_0110, 11'b101_0110_0000, 11'b101_1001_1001,
    11'b010_0001_0011, 11'b010_0100_1100, 11'b010_1111_0000,
    11'b110_1110_1111, 11'b011_1000_1100, 11'b100_0100_0111,
    11'b001_0011_1111, 11'b001_1110_1110
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] sw;
  logic [2:0] part;
  logic [3:0] lights;
  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  partition_light_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sw_lvl(sw),
    .part_closed(part), .light_on(lights)
  );

  function automatic logic [3:0] group_mask(input logic [2:0] p, input int room);
    logic [3:0] m = '0;
    int lo = room;
    int hi = room;
    while (lo > 0 && !p[lo-1]) lo--;
    while (hi < 3 && !p[hi]) hi++;
    for (int j = lo; j <= hi; j++) m[j] = 1'b1;
    return m;
  endfunction

  function automatic logic [3:0] ref_lights(input logic [2:0] p, input logic [3:0] s);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = ^(s & group_mask(p, i));
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] p);
    case (p)
      3'b111:  return "R1";
      3'b000:  return "R2";
      3'b101:  return "R3";
      3'b010:  return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b (part=%b sw=%b)", tag, act, exp, part, sw);
    end
  endtask

  task automatic apply(input logic [2:0] p, input logic [3:0] s);
    @(negedge clk);
    part = p;
    sw   = s;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] base_out;
    rst_n = 1'b0;
    part  = 3'b000;
    sw    = 4'b0001;
    repeat (3) @(negedge clk);
    check("R9 reset from start", lights, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 first load after reset", lights, 4'b1111);

    // Table walk: named arrangements and mixed patterns, hand-computed.
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][10:8], VEC[i][7:4]);
      check(tag_of(VEC[i][10:8]), lights, VEC[i][3:0]);
    end

    // R5 / R6: every input combination against the group model.
    for (int c = 0; c < 128; c++) begin
      apply(c[6:4], c[3:0]);
      check("R5 sweep", lights, ref_lights(c[6:4], c[3:0]));
      for (int k = 0; k < 3; k++) begin
        if (!part[k]) check("R6 merged pair", {3'b000, lights[k+1]}, {3'b000, lights[k]});
      end
    end

    // R7: single flips under each partition pattern.
    for (int p = 0; p < 8; p++) begin
      apply(p[2:0], 4'b0101);
      base_out = lights;
      for (int r = 0; r < 4; r++) begin
        apply(p[2:0], 4'b0101 ^ (4'b0001 << r));
        check("R7 flip", lights ^ base_out, group_mask(p[2:0], r));
      end
    end

    // R8: latency of one clock.
    apply(3'b111, 4'b0000);
    @(negedge clk);
    part = 3'b111;
    sw   = 4'b1111;
    #5;
    check("R8 before edge", lights, 4'b0000);
    @(negedge clk);
    check("R8 after edge", lights, 4'b1111);

    // R9: reset during operation.
    rst_n = 1'b0;
    #1;
    check("R9 mid-run reset", lights, 4'b0000);
    @(negedge clk);
    check("R9 reset held", lights, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", lights, 4'b1111);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule